// File: doc/BRIEF.md
# Destination Address Acceptance Filter

This block decides, for each destination address presented to it, whether the receive path should keep or drop the frame. It holds eight exact-match station address slots, of which slot 0 serves as the primary station address. It also holds a 64-entry single-bit table for group (multicast) addresses. Software loads the slots and the table through a simple write port. Each write carries a register select and a 32-bit data word, and each table write sets or clears one table bit.

When the parser raises `da_valid` with a 48-bit address on `da`, the filter compares the address with every valid slot. For a group address it also folds the address into a 6-bit index and reads the table bit at that index. Raising `promisc` forces acceptance. The decision appears on `accept` together with `accept_valid` in the cycle after the strobe.

A small two-state machine times the result. `ST_IDLE` waits for a strobe and moves to `ST_REPORT` when `da_valid` is high. `ST_REPORT` presents the registered decision for one cycle. It stays in `ST_REPORT` when another strobe arrives and returns to `ST_IDLE` otherwise.

Top module: `mhf_filter_top`

## Requirements
- R1: After reset `accept_valid` and `accept` are 0, every slot is invalid and every table entry is clear, so any presented address, unicast or group, is rejected while `promisc` is 0.
- R2: `accept_valid` is high in exactly the cycle after each cycle with `da_valid` high, and is 0 otherwise. `accept` is 0 whenever `accept_valid` is 0.
- R3: For slot k (0..7), a write with `wr_sel`=2k loads the low word and a write with `wr_sel`=2k+1 loads the upper word. Address bit 47:40 (byte 0) is low-word bits 7:0, byte 1 is bits 15:8, byte 2 is bits 23:16 and byte 3 is bits 31:24. Byte 4 (address bits 15:8) is upper-word bits 7:0 and byte 5 (address bits 7:0) is upper-word bits 15:8. Upper-word bit 16 is the slot valid flag. A presented address equal to a valid slot's address is accepted.
- R4: Writing a slot's upper word with bit 16 clear makes that slot invalid, and its address is then rejected unless some other rule accepts it.
- R5: The table index of an address has bit (5-i) equal to the XOR of address bits 8i+7 down to 8i, for i = 0..5.
- R6: A write with `wr_sel`=16 uses data bits 5:0 as the table index. Data bit 8 set enables that entry and bit 8 clear disables it. No other entry changes.
- R7: Only group addresses use the table. An address is a group address when address bit 40 is 1, and an address with bit 40 clear is not accepted through the table even if its entry is set.
- R8: With `promisc` high in the strobe cycle, the address is accepted regardless of slots and table.
- R9: An address is accepted only by a valid slot match, by a set table entry for a group address, or by `promisc`. Every other address is rejected.
- R10: All eight slots match independently, and loading one slot leaves the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 5 | Register select: 2k/2k+1 slot k low/upper word, 16 table control |
| wr_data | input | 32 | Register write data |
| promisc | input | 1 | Accept every presented address |
| da_valid | input | 1 | Destination address strobe |
| da | input | 48 | Destination address, bit 40 is the group flag |
| accept_valid | output | 1 | Decision present, one cycle after the strobe |
| accept | output | 1 | 1 keeps the frame, 0 drops it |

## Verification
Register writes take effect at the clock edge that samples them, so a strobe in a later cycle sees the new state. The decision for a strobe is captured at the edge that samples `da_valid` and is read at the following falling edge, one cycle after the strobe. The next falling edge confirms that `accept_valid` has fallen back to 0. The bench drives each strobe alone for a single cycle and compares against a model whose slots and table are updated only once each write has completed.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
    localparam int ADDR_W   = 48;
    localparam int WORD_W   = 32;
    localparam int BYTE_W   = 8;
    localparam int GROUP_BIT = 40;
    localparam int VALID_BIT = 16;
    localparam int SET_BIT   = 8;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } mhf_state_t;

    // Rebuild a stored 48-bit address from its low and upper words.
    function automatic logic [ADDR_W-1:0] words_to_addr(input logic [WORD_W-1:0] lo,
                                                        input logic [WORD_W-1:0] hi);
        logic [ADDR_W-1:0] a;
        for (int b = 0; b < 6; b++) begin
            if (b < 4)
                a[ADDR_W-1-BYTE_W*b -: BYTE_W] = lo[BYTE_W*b +: BYTE_W];
            else
                a[ADDR_W-1-BYTE_W*b -: BYTE_W] = hi[BYTE_W*(b-4) +: BYTE_W];
        end
        return a;
    endfunction
endpackage

// File: rtl/mhf_addr_bank.sv
module mhf_addr_bank
    import mhf_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    parameter int SEL_W     = 5
)(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [SEL_W-1:0]       wr_sel,
    input  logic [WORD_W-1:0]      wr_data,
    input  logic [ADDR_W-1:0]      da,
    output logic [NUM_SLOTS-1:0]   slot_hit
);
    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
        localparam logic [SEL_W-1:0] SEL_LO = SEL_W'(2*k);
        localparam logic [SEL_W-1:0] SEL_HI = SEL_W'(2*k+1);

        logic [WORD_W-1:0] lo_q;
        logic [WORD_W-1:0] hi_q;
        logic              valid_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lo_q    <= '0;
                hi_q    <= '0;
                valid_q <= 1'b0;
            end else if (wr_en) begin
                if (wr_sel == SEL_LO)
                    lo_q <= wr_data;
                if (wr_sel == SEL_HI) begin
                    hi_q    <= {{(WORD_W-VALID_BIT){1'b0}}, wr_data[VALID_BIT-1:0]};
                    valid_q <= wr_data[VALID_BIT];
                end
            end
        end

        assign slot_hit[k] = valid_q && (words_to_addr(lo_q, hi_q) == da);
    end
endmodule

// File: rtl/mhf_hash_table.sv
module mhf_hash_table
    import mhf_pkg::*;
#(
    parameter int HASH_W = 6
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tbl_we,
    input  logic [HASH_W-1:0] tbl_idx,
    input  logic              tbl_set,
    input  logic [ADDR_W-1:0] da,
    output logic              group_hit
);
    localparam int ENTRIES = 1 << HASH_W;

    logic [ENTRIES-1:0] tbl_q;
    logic [HASH_W-1:0]  hash;

    // Each hash bit folds one address byte; byte i drives bit HASH_W-1-i.
    for (genvar i = 0; i < HASH_W; i++) begin : g_fold
        assign hash[HASH_W-1-i] = ^da[BYTE_W*i +: BYTE_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            tbl_q <= '0;
        else if (tbl_we)
            tbl_q[tbl_idx] <= tbl_set;
    end

    assign group_hit = da[GROUP_BIT] && tbl_q[hash];
endmodule

// File: rtl/mhf_decide_fsm.sv
module mhf_decide_fsm
    import mhf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic da_valid,
    input  logic hit,
    output logic accept_valid,
    output logic accept
);
    mhf_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = da_valid ? ST_REPORT : ST_IDLE;
            ST_REPORT: state_d = da_valid ? ST_REPORT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            accept <= 1'b0;
        else
            accept <= da_valid && hit;
    end

    assign accept_valid = (state_q == ST_REPORT);
endmodule

// File: rtl/mhf_filter_top.sv
module mhf_filter_top
    import mhf_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    parameter int HASH_W    = 6,
    localparam int SEL_W    = $clog2(2*NUM_SLOTS+1)
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [31:0]       wr_data,
    input  logic              promisc,
    input  logic              da_valid,
    input  logic [47:0]       da,
    output logic              accept_valid,
    output logic              accept
);
    localparam logic [SEL_W-1:0] SEL_TBL = SEL_W'(2*NUM_SLOTS);

    logic [NUM_SLOTS-1:0] slot_hit;
    logic                 group_hit;
    logic                 hit;
    logic                 tbl_we;

    mhf_addr_bank #(.NUM_SLOTS(NUM_SLOTS), .SEL_W(SEL_W)) bank_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .da(da), .slot_hit(slot_hit)
    );

    assign tbl_we = wr_en && (wr_sel == SEL_TBL);

    mhf_hash_table #(.HASH_W(HASH_W)) table_i (
        .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we),
        .tbl_idx(wr_data[HASH_W-1:0]), .tbl_set(wr_data[SET_BIT]),
        .da(da), .group_hit(group_hit)
    );

    assign hit = promisc || (|slot_hit) || group_hit;

    mhf_decide_fsm fsm_i (
        .clk(clk), .rst_n(rst_n), .da_valid(da_valid), .hit(hit),
        .accept_valid(accept_valid), .accept(accept)
    );
endmodule

// File: rtl/mhf_checker.sv
module mhf_checker #(
    parameter int NUM_SLOTS = 8
)(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 promisc,
    input logic                 da_valid,
    input logic [47:0]          da,
    input logic [NUM_SLOTS-1:0] slot_hit,
    input logic                 accept_valid,
    input logic                 accept
);
    assert_result_due_R2: assert property (@(posedge clk) disable iff (!rst_n)
        da_valid |=> accept_valid);

    assert_no_stray_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !da_valid |=> !accept_valid);

    assert_accept_qualified_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> accept_valid);

    assert_promisc_accepts_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (da_valid && promisc) |=> accept);

    assert_slot_accepts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (da_valid && (|slot_hit)) |=> accept);

    assert_unicast_reject_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (da_valid && !promisc && !da[40] && (slot_hit == '0)) |=> !accept);
endmodule

bind mhf_filter_top mhf_checker #(.NUM_SLOTS(NUM_SLOTS)) chk_i (
    .clk(clk), .rst_n(rst_n), .promisc(promisc), .da_valid(da_valid), .da(da),
    .slot_hit(slot_hit), .accept_valid(accept_valid), .accept(accept)
);

// File: tb/mhf_filter_top_tb.sv
module mhf_filter_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic        promisc = 1'b0;
    logic        da_valid = 1'b0;
    logic [47:0] da = '0;
    logic        accept_valid;
    logic        accept;

    int checks = 0;
    int failures = 0;

    logic [31:0] m_lo [8];
    logic [31:0] m_hi [8];
    logic        m_v  [8];
    logic [63:0] m_tbl;

    always #5 clk = ~clk;

    mhf_filter_top dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .promisc(promisc), .da_valid(da_valid), .da(da),
        .accept_valid(accept_valid), .accept(accept)
    );

    function automatic logic [5:0] ref_hash(input logic [47:0] a);
        logic [5:0] h;
        for (int i = 0; i < 6; i++) begin
            logic p = 1'b0;
            for (int j = 0; j < 8; j++) p = p ^ a[8*i + j];
            h[5-i] = p;
        end
        return h;
    endfunction

    function automatic logic [47:0] slot_addr(input int k);
        return {m_lo[k][7:0], m_lo[k][15:8], m_lo[k][23:16], m_lo[k][31:24],
                m_hi[k][7:0], m_hi[k][15:8]};
    endfunction

    function automatic logic ref_accept(input logic [47:0] a, input logic p);
        logic r = p;
        for (int k = 0; k < 8; k++)
            if (m_v[k] && slot_addr(k) == a) r = 1'b1;
        if (a[40] && m_tbl[ref_hash(a)]) r = 1'b1;
        return r;
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [4:0] sel, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
        if (sel < 5'd16) begin
            if (sel[0]) begin
                m_hi[sel[4:1]] = {16'h0, data[15:0]};
                m_v[sel[4:1]]  = data[16];
            end else
                m_lo[sel[4:1]] = data;
        end else if (sel == 5'd16)
            m_tbl[data[5:0]] = data[8];
    endtask

    task automatic load_slot(input int k, input logic [47:0] a, input logic v);
        write_reg(5'(2*k), {a[23:16], a[31:24], a[39:32], a[47:40]});
        write_reg(5'(2*k+1), {15'h0, v, a[7:0], a[15:8]});
    endtask

    task automatic present(input string req, input logic [47:0] a, input logic p);
        logic exp;
        exp = ref_accept(a, p);
        @(negedge clk);
        da = a; promisc = p; da_valid = 1'b1;
        @(negedge clk);
        da_valid = 1'b0; promisc = 1'b0;
        check({req, " valid"}, accept_valid, 1'b1);
        check(req, accept, exp);
        @(negedge clk);
        check("R2 drop", accept_valid, 1'b0);
    endtask

    initial begin
        #2000000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [47:0] g, u, a;
        int r;
        for (int k = 0; k < 8; k++) begin m_lo[k] = '0; m_hi[k] = '0; m_v[k] = 1'b0; end
        m_tbl = '0;
        r = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        check("R1 reset valid", accept_valid, 1'b0);
        check("R1 reset accept", accept, 1'b0);
        rst_n = 1'b1;
        present("R1 zero addr", 48'h0, 1'b0);
        present("R1 group addr", 48'h0100_0000_0000, 1'b0);
        check("R1 model", ref_accept(48'h0100_0000_0000, 1'b0), 1'b0);

        a = 48'h0200_1234_5678;
        load_slot(0, a, 1'b1);
        present("R3 primary", a, 1'b0);
        present("R9 near miss", a ^ 48'h1, 1'b0);
        for (int k = 1; k < 8; k++)
            load_slot(k, {8'h02, 8'(k), 32'hA5A5_0000 + 32'(k * 7)}, 1'b1);
        for (int k = 0; k < 8; k++)
            present("R10 slot", slot_addr(k), 1'b0);
        g = slot_addr(3);
        load_slot(3, g, 1'b0);
        present("R4 invalidated", g, 1'b0);
        present("R10 neighbour", slot_addr(4), 1'b0);

        g = 48'h0180_C200_0001;
        write_reg(5'd16, {23'h0, 1'b1, 2'b00, ref_hash(g)});
        present("R5 group hit", g, 1'b0);
        check("R5 model", ref_accept(g, 1'b0), 1'b1);
        u = g ^ 48'h0300_0000_0000;
        present("R7 unicast same hash", u, 1'b0);
        present("R6 other index", g ^ 48'h0000_0000_0001, 1'b0);
        write_reg(5'd16, {23'h0, 1'b0, 2'b00, ref_hash(g)});
        present("R6 cleared", g, 1'b0);
        present("R8 promisc", 48'h0000_DEAD_BEEF, 1'b1);

        for (int n = 0; n < 400; n++) begin
            r = int'($urandom_range(0, 5));
            case (r)
                0: load_slot(int'($urandom_range(0, 7)),
                             {$urandom(), 16'($urandom())}, 1'($urandom_range(0, 3) != 0));
                1: write_reg(5'd16, {23'h0, 1'($urandom()), 2'b00, 6'($urandom())});
                2: present("R3 random slot", slot_addr(int'($urandom_range(0, 7))), 1'b0);
                3: present("R5 random group", {$urandom(), 16'($urandom())} | 48'h0100_0000_0000, 1'b0);
                4: present("R9 random", {$urandom(), 16'($urandom())}, 1'b0);
                default: present("R8 random promisc", {$urandom(), 16'($urandom())}, 1'b1);
            endcase
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule